// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block routes device interrupts in a chipset that serves four processors. Up to 64 device request lines feed one shared request register. Bits are set through a post vector and cleared through a withdraw vector. Each processor has its own 64-bit enable mask. It also has a pending register, which always holds that mask ANDed with the shared request register. One interrupt output per processor is high while that processor's pending register is nonzero. A separate real-time-clock interrupt is raised by an event input and acknowledged through a miscellaneous control register.

Software reaches the registers over a plain 64-bit register bus. A request carries a byte address, a size code, a write flag, write data and the identity of the requesting processor. One cycle later a response returns read data or an error flag. Registers sit in 64-byte slots, and the slot index is taken from the address bits above bit 5. Slot layout with four processors: 0 control/status, 1 misc, 2..5 mask of CPU0..3, 6..9 pending of CPU0..3, 10 shared request. All other slots are unknown.

Top module: `irq_router`

## Requirements
- R1: After reset all masks, pending registers, the shared request register and the misc register are zero, and every processor output, the RTC output and the response valid and error flags are low.
- R2: The register slot is `req_addr[ADDR_W-1:6]`, mapped as 0 control, 1 misc, 2+n mask of CPU n, 6+n pending of CPU n, 10 shared request. An access with `req_addr[5:0]` nonzero, or to any other slot, is an error.
- R3: Only size code 3 (64-bit) is legal. Codes 0, 1 and 2 (8, 16 and 32 bit) give an error, read data zero, and change no state.
- R4: Bits set in `dev_post` are set in the shared request register on the next edge. Each CPU whose mask covers a posted bit gets that bit in its pending register, and its output is high from that edge.
- R5: Bits set in `dev_withdraw` are cleared in the shared request register and in every pending register. A CPU output falls when its pending register becomes zero. If a bit is posted and withdrawn in the same cycle, the post wins.
- R6: A legal mask write stores the data. The CPU's pending register becomes the new mask ANDed with the shared request register, and this includes clearing it and dropping the output when the overlap is zero.
- R7: A misc read returns the stored misc value ORed with `req_cpu` in bits [1:0].
- R8: A misc write with bit 4 set clears misc bit 4 and the RTC output. A misc write with bit 4 clear is an error and changes nothing.
- R9: `rtc_event` sets misc bit 4 and the RTC output on the next edge. If it coincides with a clearing misc write, the event wins.
- R10: The control register reads as zero. Writes to the control, pending or shared-request registers are errors and change nothing.
- R11: Each request gets a response exactly one cycle later, and no response appears without a request. Read data reflect the state before any update in the request's own cycle. Write and error responses carry zero data.
- R12: Each processor's output always equals the OR of its pending register, and a pending register never holds a bit its mask lacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bit |
| req_addr | input | ADDR_W (10) | Byte address within the block window |
| req_cpu | input | CPU_W (2) | Identity of the requesting processor |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W (64) | Read data, zero for writes and errors |
| dev_post | input | DATA_W (64) | Device request bits to raise |
| dev_withdraw | input | DATA_W (64) | Device request bits to drop |
| rtc_event | input | 1 | Real-time-clock tick |
| cpu_irq | output | NUM_CPU (4) | Device interrupt per processor |
| rtc_irq | output | 1 | Real-time-clock interrupt |

## Verification
The routing path is tried with three kinds of masks. Disjoint masks show that a posted line reaches only the processors that enable it. Overlapping masks show that one line fans out to several outputs and that each output falls separately on withdrawal. A mask written after the requests are already present shows that the pending register is recomputed from the stored requests. Simultaneous post and withdraw of the same bit, a zero-overlap mask write and a coinciding RTC event and acknowledge each isolate one ordering rule. A long run with random posts, withdrawals, mask writes and reads then compares the design against the reference model on every cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Kind of register addressed by a bus request
    typedef enum logic [2:0] {
        K_NONE,
        K_CTRL,
        K_MISC,
        K_MASK,
        K_PEND,
        K_RAW,
        K_BAD
    } reg_kind_e;

    localparam logic [1:0] SIZE_DW = 2'd3;   // only legal access size: 64 bit
    localparam int         RTC_BIT = 4;      // misc bit holding the RTC state

endpackage

// File: rtl/irq_router_regdec.sv
module irq_router_regdec
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 10,
    parameter int CPU_W   = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_rtc_bit,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  sel,
    output logic              err
);
    localparam int IDX_W = ADDR_W - 6;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(0);
    localparam logic [IDX_W-1:0] MISC_IDX = IDX_W'(1);
    localparam logic [IDX_W-1:0] MASK_LO  = IDX_W'(2);
    localparam logic [IDX_W-1:0] PEND_LO  = IDX_W'(2 + NUM_CPU);
    localparam logic [IDX_W-1:0] RAW_IDX  = IDX_W'(2 + 2 * NUM_CPU);

    logic [IDX_W-1:0] idx;
    logic             off_bad;

    assign idx     = req_addr[ADDR_W-1:6];
    assign off_bad = (req_addr[5:0] != 6'd0);

    always_comb begin
        kind = K_NONE;
        sel  = '0;
        err  = 1'b0;
        if (req_valid) begin
            if (off_bad) begin
                kind = K_BAD;
            end else if (idx == CTRL_IDX) begin
                kind = K_CTRL;
            end else if (idx == MISC_IDX) begin
                kind = K_MISC;
            end else if (idx >= MASK_LO && idx < PEND_LO) begin
                kind = K_MASK;
                sel  = CPU_W'(idx - MASK_LO);
            end else if (idx >= PEND_LO && idx < RAW_IDX) begin
                kind = K_PEND;
                sel  = CPU_W'(idx - PEND_LO);
            end else if (idx == RAW_IDX) begin
                kind = K_RAW;
            end else begin
                kind = K_BAD;
            end
            err = (req_size != SIZE_DW)
                | (kind == K_BAD)
                | (req_write & (kind inside {K_CTRL, K_PEND, K_RAW}))
                | (req_write & (kind == K_MISC) & ~wr_rtc_bit);
        end
    end

endmodule

// File: rtl/irq_router_slice.sv
module irq_router_slice #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic [DATA_W-1:0] raw_d,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] pend_q,
    output logic              irq_q
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] pend;
        logic              irq;
    } slice_st_t;

    slice_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        st_d.pend = st_d.mask & raw_d;
        st_d.irq  = (st_d.pend != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign pend_q = st_q.pend;
    assign irq_q  = st_q.irq;

    // R6
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    // R12
    pend_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q) == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 10,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [DATA_W-1:0]  dev_post,
    input  logic [DATA_W-1:0]  dev_withdraw,
    input  logic               rtc_event,
    output logic [NUM_CPU-1:0] cpu_irq,
    output logic               rtc_irq
);
    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] misc;
        logic              rtc;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    reg_kind_e        kind;
    logic [CPU_W-1:0] sel;
    logic             err;
    logic             wr_ok;
    logic             rtc_ack;

    logic [DATA_W-1:0] mask_a [NUM_CPU];
    logic [DATA_W-1:0] pend_a [NUM_CPU];

    irq_router_regdec #(
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W),
        .CPU_W   (CPU_W)
    ) i_regdec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .wr_rtc_bit (req_wdata[RTC_BIT]),
        .kind       (kind),
        .sel        (sel),
        .err        (err)
    );

    assign wr_ok   = req_valid & req_write & ~err;
    assign rtc_ack = wr_ok & (kind == K_MISC);

    always_comb begin
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~dev_withdraw) | dev_post;

        if (rtc_ack) begin
            st_d.misc[RTC_BIT] = 1'b0;
            st_d.rtc           = 1'b0;
        end
        if (rtc_event) begin
            st_d.misc[RTC_BIT] = 1'b1;
            st_d.rtc           = 1'b1;
        end

        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid & err;
        st_d.rsp_rdata = '0;
        if (req_valid && !req_write && !err) begin
            case (kind)
                K_MISC:  st_d.rsp_rdata = st_q.misc | DATA_W'(req_cpu);
                K_MASK:  st_d.rsp_rdata = mask_a[sel];
                K_PEND:  st_d.rsp_rdata = pend_a[sel];
                K_RAW:   st_d.rsp_rdata = st_q.raw;
                default: st_d.rsp_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic we_c;
        assign we_c = wr_ok & (kind == K_MASK) & (sel == CPU_W'(c));

        irq_router_slice #(
            .DATA_W (DATA_W)
        ) i_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (we_c),
            .mask_wdata (req_wdata),
            .raw_d      (st_d.raw),
            .mask_q     (mask_a[c]),
            .pend_q     (pend_a[c]),
            .irq_q      (cpu_irq[c])
        );

        // R12
        irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_irq[c] == (pend_a[c] != '0)));

        // R5
        withdraw_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_withdraw != '0) |=> ((pend_a[c] & $past(dev_withdraw & ~dev_post)) == '0));
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;
    assign rtc_irq   = st_q.rtc;

    // R4
    post_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_post != '0) |=> ((st_q.raw & $past(dev_post)) == $past(dev_post)));

    // R9
    rtc_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_event |=> rtc_irq);

    // R3
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != SIZE_DW) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int NC = 4;
    localparam int DW = 64;
    localparam int AW = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [1:0]     req_size = 2'd3;
    logic [AW-1:0]  req_addr = '0;
    logic [1:0]     req_cpu = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           rsp_valid;
    logic           rsp_err;
    logic [DW-1:0]  rsp_rdata;
    logic [DW-1:0]  dev_post = '0;
    logic [DW-1:0]  dev_withdraw = '0;
    logic           rtc_event = 1'b0;
    logic [NC-1:0]  cpu_irq;
    logic           rtc_irq;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dev_post(dev_post), .dev_withdraw(dev_withdraw), .rtc_event(rtc_event),
        .cpu_irq(cpu_irq), .rtc_irq(rtc_irq)
    );

    always #4 clk = ~clk;   // 125 MHz

    // reference model state
    logic [DW-1:0] m_mask [NC];
    logic [DW-1:0] m_pend [NC];
    logic [DW-1:0] m_raw, m_misc;
    logic          m_rtc, e_valid, e_err;
    logic [DW-1:0] e_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            m_mask[i] = '0;
            m_pend[i] = '0;
        end
        m_raw = '0; m_misc = '0; m_rtc = 1'b0;
        e_valid = 1'b0; e_err = 1'b0; e_rdata = '0;
    endtask

    // behavioural update at a clock edge, from the inputs held over that edge
    task automatic model_step();
        int  slot;
        bit  bad;
        logic [DW-1:0] rd;
        slot = int'(req_addr) / 64;
        bad  = 1'b0;
        rd   = '0;
        if (req_valid) begin
            if (req_size != 2'd3 || (int'(req_addr) % 64) != 0) bad = 1'b1;
            else if (slot == 0) begin
                if (req_write) bad = 1'b1;
            end else if (slot == 1) begin
                if (req_write && !req_wdata[4]) bad = 1'b1;
                else if (!req_write) rd = m_misc | DW'(req_cpu);
            end else if (slot >= 2 && slot < 2 + NC) begin
                if (!req_write) rd = m_mask[slot - 2];
            end else if (slot >= 2 + NC && slot < 2 + 2 * NC) begin
                if (req_write) bad = 1'b1; else rd = m_pend[slot - 2 - NC];
            end else if (slot == 2 + 2 * NC) begin
                if (req_write) bad = 1'b1; else rd = m_raw;
            end else bad = 1'b1;
        end
        e_valid = req_valid;
        e_err   = req_valid && bad;
        e_rdata = (req_valid && !bad && !req_write) ? rd : '0;

        m_raw = (m_raw & ~dev_withdraw) | dev_post;
        if (req_valid && req_write && !bad) begin
            if (slot >= 2 && slot < 2 + NC) m_mask[slot - 2] = req_wdata;
            if (slot == 1) begin
                m_misc[4] = 1'b0;
                m_rtc     = 1'b0;
            end
        end
        if (rtc_event) begin
            m_misc[4] = 1'b1;
            m_rtc     = 1'b1;
        end
        for (int i = 0; i < NC; i++) m_pend[i] = m_mask[i] & m_raw;
    endtask

    task automatic compare();
        logic [NC-1:0] e_irq;
        for (int i = 0; i < NC; i++) e_irq[i] = (m_pend[i] != '0);
        n_cmp++;
        if (cpu_irq !== e_irq || rtc_irq !== m_rtc || rsp_valid !== e_valid ||
            rsp_err !== e_err || rsp_rdata !== e_rdata) begin
            n_bad++;
            $display("FAIL %s: irq=%b rtc=%b vld=%b err=%b rd=%h expected irq=%b rtc=%b vld=%b err=%b rd=%h",
                     tag, cpu_irq, rtc_irq, rsp_valid, rsp_err, rsp_rdata,
                     e_irq, m_rtc, e_valid, e_err, e_rdata);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        compare();
        req_valid = 1'b0; dev_post = '0; dev_withdraw = '0; rtc_event = 1'b0;
    endtask

    task automatic acc(input bit w, input int slot, input logic [DW-1:0] d,
                       input logic [1:0] cpu = 2'd0, input logic [1:0] sz = 2'd3);
        req_valid = 1'b1; req_write = w; req_addr = AW'(slot * 64);
        req_wdata = d; req_cpu = cpu; req_size = sz;
    endtask

    bit finished = 1'b0;

    initial begin
        model_reset();
        repeat (3) cycle();
        rst_n = 1'b1;
        tag = "R1"; cycle(); cycle();                          // R1 idle reset state

        tag = "R10"; acc(0, 0, '0); cycle(); cycle();          // R10 control reads zero
        tag = "R7";  acc(0, 1, '0, 2'd2); cycle(); cycle();    // R7 misc read shows cpu id

        tag = "R6";                                            // R6 disjoint / overlapping masks
        acc(1, 2, 64'h00FF); cycle();
        acc(1, 3, 64'hFF00); cycle();
        acc(1, 4, 64'hF0F0); cycle(); cycle();
        tag = "R4"; dev_post = 64'h8; cycle(); cycle();        // R4 reaches CPU0 only
        dev_post = 64'h1000; cycle(); cycle();                 // R4 fans out to CPU1, CPU2
        tag = "R11"; acc(0, 8, '0); cycle(); acc(0, 10, '0); cycle(); cycle();   // R11
        tag = "R11"; acc(0, 10, '0); dev_post = 64'h2; cycle(); cycle();          // R11 old value
        tag = "R5"; dev_withdraw = 64'h1000; cycle(); cycle(); // R5 CPU1/2 drop
        tag = "R5"; dev_post = 64'h20; dev_withdraw = 64'h20; cycle(); acc(0, 10, '0); cycle(); cycle();
        tag = "R6"; acc(1, 5, 64'h20); cycle(); cycle();       // R6 mask after request present
        tag = "R6"; acc(1, 2, 64'hFF00_0000); cycle(); acc(0, 6, '0); cycle(); cycle();  // R6 zero overlap

        tag = "R3";                                            // R3 narrow sizes
        for (int s = 0; s < 3; s++) begin
            acc(1, 3, 64'h0, 2'd0, 2'(s)); cycle();
            acc(0, 3, 64'h0, 2'd0, 2'(s)); cycle();
        end
        acc(0, 3, '0); cycle(); cycle();
        tag = "R2"; req_valid = 1'b1; req_write = 1'b0; req_size = 2'd3; req_addr = AW'(3 * 64 + 8);
        cycle(); acc(0, 13, '0); cycle(); acc(0, 5, '0); cycle(); cycle();   // R2
        tag = "R10"; acc(1, 0, '1); cycle(); acc(1, 7, '1); cycle();         // R10
        acc(1, 10, '0); cycle(); acc(0, 7, '0); cycle(); acc(0, 10, '0); cycle(); cycle();

        tag = "R9"; rtc_event = 1'b1; cycle(); acc(0, 1, '0, 2'd3); cycle(); cycle();   // R9
        tag = "R8"; acc(1, 1, 64'h1); cycle(); acc(0, 1, '0, 2'd1); cycle();            // R8 error
        acc(1, 1, 64'h10); cycle(); acc(0, 1, '0); cycle(); cycle();                     // R8 clear
        tag = "R9"; rtc_event = 1'b1; cycle(); acc(1, 1, 64'h10); rtc_event = 1'b1; cycle(); cycle();  // R9 wins

        tag = "R12";                                           // R12 random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) dev_post = DW'(64'(1) << $urandom_range(0, 63)) | DW'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) dev_withdraw = {$urandom, $urandom};
            if ($urandom_range(0, 15) == 0) rtc_event = 1'b1;
            if (r < 4) acc(r == 0, int'($urandom_range(0, 15)), {$urandom, $urandom},
                           2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0) ? 2'd1 : 2'd3);
            cycle();
        end
        repeat (3) cycle();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule